// File: doc/BRIEF.md
# Mode-Configurable Watchdog Timer

This block is a watchdog counter that advances on a slow tick of nominally 1 ms, which comes from an oscillator independent of the core clock. If software does not clear the counter before the selected period elapses, the block pulses a system reset request. If the core is asleep at that moment, the block requests a wake instead of a reset, so the core resumes where it stopped. A 2-bit configuration field selects one of four enable policies. One of these policies follows a software enable bit.

The period select is a 5-bit value n. It gives a timeout of 2^n ticks, and values above the maximum exponent saturate. The counter restarts from zero on several events: a clear command, sleep entry, sleep exit, an oscillator-fail indication, a disabled watchdog, and every timeout. Two active-low status flags record what happened. The first records that a watchdog timeout occurred. The second records that the core entered sleep.

Top module: `wdog_core`

## Requirements
- R1: Each rising edge of the asynchronous tick input advances the counter exactly once, however long the tick stays high.
- R2: The enable field works as follows. A value of 2'b11 enables the watchdog at all times. A value of 2'b10 enables it only while `asleep` is 0. A value of 2'b01 enables it exactly when `sw_en` is 1. A value of 2'b00 disables it.
- R3: With period select n, a timeout occurs after 2^min(n, MAX_EXP) counted ticks.
- R4: After reset, the period select holds PSEL_RST.
- R5: A `clr_cmd` or `osc_fail` pulse discards the ticks counted so far.
- R6: Sleep entry (rising `asleep`) and sleep exit (falling `asleep`) each discard the ticks counted so far. When the mode keeps the watchdog enabled in sleep, counting resumes after entry.
- R7: While the watchdog is disabled, ticks are not counted and the count returns to zero.
- R8: A timeout while awake drives `sys_rst_req` high for exactly one clock, and counting restarts from zero.
- R9: A timeout while asleep drives `wake_req` high for one clock and never drives `sys_rst_req`.
- R10: `to_n` goes to 0 on any timeout. `pd_n` goes to 0 on sleep entry and goes to 1 on an awake timeout. `clr_cmd` sets both flags to 1. Both flags reset to 1.
- R11: A clock with `period_we` high loads `period_wdata` into the period select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_async | input | 1 | Slow tick from the independent oscillator |
| en_mode | input | 2 | Enable policy select |
| sw_en | input | 1 | Software enable bit, used in mode 2'b01 |
| asleep | input | 1 | Core is in low-power sleep |
| clr_cmd | input | 1 | Clear-watchdog command pulse |
| osc_fail | input | 1 | Oscillator-fail indication |
| period_we | input | 1 | Period select write strobe |
| period_wdata | input | PSEL_W | New period select value |
| sys_rst_req | output | 1 | One-clock system reset request |
| wake_req | output | 1 | One-clock wake request |
| to_n | output | 1 | Active-low timeout flag |
| pd_n | output | 1 | Active-low power-down flag |

## Verification
The bench builds the block with MAX_EXP set to 6 and PSEL_RST set to 3. With these values, the saturation of large period selects is reached within 64 ticks, and the reset-default period is reached within 8 ticks. Short periods of 1, 2 and 4 ticks bring the boundary between the last silent tick and the timing-out tick within reach for every clear source, and for both sleep edges.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [1:0] {
    WM_OFF    = 2'b00,
    WM_SOFT   = 2'b01,
    WM_AWAKE  = 2'b10,
    WM_ALWAYS = 2'b11
  } wd_mode_e;

  // Effective exponent after saturation.
  function automatic int unsigned eff_exp(input int unsigned sel, input int unsigned max_e);
    return (sel > max_e) ? max_e : sel;
  endfunction

  // Enable decision for a given policy, software bit and sleep state.
  function automatic logic mode_enable(input wd_mode_e m, input logic sw, input logic slp);
    case (m)
      WM_ALWAYS: return 1'b1;
      WM_AWAKE:  return ~slp;
      WM_SOFT:   return sw;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/wdog_tick_sync.sv
module wdog_tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  output logic tick_pulse
);
  logic [STAGES-1:0] sync_q;
  logic              edge_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= tick_in;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q[i] <= 1'b0;
        else        sync_q[i] <= sync_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) edge_q <= 1'b0;
    else        edge_q <= sync_q[STAGES-1];

  assign tick_pulse = sync_q[STAGES-1] & ~edge_q;

  // R1: a tick pulse never lasts two cycles
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tick_pulse |=> !tick_pulse);
endmodule

// File: rtl/wdog_mode_ctl.sv
module wdog_mode_ctl
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       sw_en,
  input  logic       asleep,
  output logic       run_en,
  output logic       slp_entry,
  output logic       slp_exit
);
  logic asleep_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) asleep_q <= 1'b0;
    else        asleep_q <= asleep;

  assign slp_entry = asleep & ~asleep_q;
  assign slp_exit  = ~asleep & asleep_q;
  assign run_en    = mode_enable(wd_mode_e'(mode_i), sw_en, asleep);

  // R6: entry and exit are never seen together
  a_r6_edges_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(slp_entry && slp_exit));
  // R2: mode 00 never enables
  a_r2_off_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b00) |-> !run_en);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int PSEL_W   = 5,
  parameter int MAX_EXP  = 18,
  parameter int PSEL_RST = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_pulse,
  input  logic              run_en,
  input  logic              clr_any,
  input  logic              period_we,
  input  logic [PSEL_W-1:0] period_wdata,
  output logic              expire
);
  localparam int CNT_W = MAX_EXP + 1;

  logic [PSEL_W-1:0] psel_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  lim_m1;
  logic              step;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         psel_q <= PSEL_W'(PSEL_RST);
    else if (period_we) psel_q <= period_wdata;

  assign lim_m1 = (CNT_W'(1) << eff_exp(int'(psel_q), MAX_EXP)) - CNT_W'(1);
  assign step   = run_en & ~clr_any & tick_pulse;
  assign expire = step & (cnt_q >= lim_m1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)               cnt_q <= '0;
    else if (clr_any || !run_en) cnt_q <= '0;
    else if (expire)          cnt_q <= '0;
    else if (step)            cnt_q <= cnt_q + CNT_W'(1);

  // R7: disabled watchdog holds zero
  a_r7_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (cnt_q == '0));
  // R5: any clear source empties the counter
  a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr_any |=> (cnt_q == '0));
  // R1: the count only grows on a tick
  a_r1_step_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && cnt_q != $past(cnt_q)) |-> $past(tick_pulse));
endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
  parameter int PSEL_W      = 5,
  parameter int MAX_EXP     = 18,
  parameter int PSEL_RST    = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_async,
  input  logic [1:0]        en_mode,
  input  logic              sw_en,
  input  logic              asleep,
  input  logic              clr_cmd,
  input  logic              osc_fail,
  input  logic              period_we,
  input  logic [PSEL_W-1:0] period_wdata,
  output logic              sys_rst_req,
  output logic              wake_req,
  output logic              to_n,
  output logic              pd_n
);
  logic tick_pulse, run_en, slp_entry, slp_exit, clr_any, expire;
  logic rst_q, wake_q, to_q, pd_q;

  wdog_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_async), .tick_pulse(tick_pulse));

  wdog_mode_ctl u_mode (
    .clk(clk), .rst_n(rst_n), .mode_i(en_mode), .sw_en(sw_en), .asleep(asleep),
    .run_en(run_en), .slp_entry(slp_entry), .slp_exit(slp_exit));

  assign clr_any = clr_cmd | osc_fail | slp_entry | slp_exit;

  wdog_counter #(.PSEL_W(PSEL_W), .MAX_EXP(MAX_EXP), .PSEL_RST(PSEL_RST)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_pulse(tick_pulse), .run_en(run_en),
    .clr_any(clr_any), .period_we(period_we), .period_wdata(period_wdata),
    .expire(expire));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rst_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      rst_q  <= expire & ~asleep;
      wake_q <= expire & asleep;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       to_q <= 1'b1;
    else if (expire)  to_q <= 1'b0;
    else if (clr_cmd) to_q <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                   pd_q <= 1'b1;
    else if (slp_entry)           pd_q <= 1'b0;
    else if (expire && !asleep)   pd_q <= 1'b1;
    else if (clr_cmd)             pd_q <= 1'b1;

  assign sys_rst_req = rst_q;
  assign wake_req    = wake_q;
  assign to_n        = to_q;
  assign pd_n        = pd_q;

  // R8: reset request lasts one clock
  a_r8_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> !sys_rst_req);
  // R9: wake and reset never together
  a_r9_wake_not_rst: assert property (@(posedge clk) disable iff (!rst_n)
    !(wake_req && sys_rst_req));
  // R10: any timeout leaves the timeout flag low
  a_r10_to_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst_req || wake_req) |-> !to_n);
  // R10: sleep entry drops the power-down flag
  a_r10_pd_entry: assert property (@(posedge clk) disable iff (!rst_n)
    slp_entry |=> !pd_n);
endmodule

// File: tb/sim_wdog_core.sv
module sim_wdog_core;
  localparam int CLK_PERIOD = 10;
  localparam int PW   = 5;
  localparam int MAXE = 6;
  localparam int PRST = 3;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic [1:0] en_mode = 2'b00;
  logic sw_en = 1'b0, asleep = 1'b0, clr_cmd = 1'b0, osc_fail = 1'b0, period_we = 1'b0;
  logic [PW-1:0] period_wdata = '0;
  logic sys_rst_req, wake_req, to_n, pd_n;

  int total = 0, bad = 0, n_rst = 0, n_wake = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_core #(.PSEL_W(PW), .MAX_EXP(MAXE), .PSEL_RST(PRST)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_async(tick), .en_mode(en_mode), .sw_en(sw_en),
    .asleep(asleep), .clr_cmd(clr_cmd), .osc_fail(osc_fail), .period_we(period_we),
    .period_wdata(period_wdata), .sys_rst_req(sys_rst_req), .wake_req(wake_req),
    .to_n(to_n), .pd_n(pd_n));

  always @(negedge clk) begin
    if (sys_rst_req) n_rst++;
    if (wake_req)    n_wake++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n, input int hold = 1);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; cyc(hold);
      tick = 1'b0; cyc(3);
    end
  endtask

  task automatic pulse_clr();
    clr_cmd = 1'b1; cyc(1); clr_cmd = 1'b0; cyc(1);
  endtask

  task automatic set_period(input int v);
    period_we = 1'b1; period_wdata = PW'(v); cyc(1); period_we = 1'b0; cyc(1);
  endtask

  task automatic zero_counts();
    n_rst = 0; n_wake = 0;
  endtask

  // {mode[1:0], sw, slp, psel[4:0], nticks[7:0]}
  localparam int NV = 12;
  localparam logic [16:0] VEC [NV] = '{
    {2'b11, 1'b0, 1'b0, 5'd2,  8'd9},
    {2'b11, 1'b0, 1'b1, 5'd2,  8'd9},
    {2'b10, 1'b0, 1'b0, 5'd1,  8'd5},
    {2'b10, 1'b0, 1'b1, 5'd1,  8'd5},
    {2'b01, 1'b1, 1'b0, 5'd0,  8'd3},
    {2'b01, 1'b0, 1'b0, 5'd0,  8'd3},
    {2'b01, 1'b1, 1'b1, 5'd2,  8'd8},
    {2'b00, 1'b1, 1'b0, 5'd0,  8'd4},
    {2'b00, 1'b0, 1'b1, 5'd0,  8'd4},
    {2'b11, 1'b0, 1'b0, 5'd31, 8'd70},
    {2'b10, 1'b1, 1'b0, 5'd7,  8'd64},
    {2'b01, 1'b0, 1'b1, 5'd1,  8'd4}
  };

  function automatic int exp_timeouts(input logic [1:0] m, input logic sw, input logic slp,
                                      input int psel, input int nt);
    bit on;
    int e;
    on = (m == 2'b11) || (m == 2'b10 && !slp) || (m == 2'b01 && sw);
    e  = (psel > MAXE) ? MAXE : psel;
    return on ? nt / (1 << e) : 0;
  endfunction

  initial begin
    cyc(3); rst_n = 1'b1; cyc(1);
    // R10 reset state of flags and outputs
    chk("R10 reset to_n", to_n, 1);
    chk("R10 reset pd_n", pd_n, 1);
    chk("R8 reset sys_rst_req", sys_rst_req, 0);
    chk("R9 reset wake_req", wake_req, 0);

    // R4: default period of 2^PRST ticks
    en_mode = 2'b11; cyc(1); zero_counts();
    ticks((1 << PRST) - 1);
    chk("R4 before default period", n_rst, 0);
    ticks(1);
    chk("R4 at default period", n_rst, 1);
    pulse_clr();

    // Table walk: R2 modes, R3 periods and saturation, R11 writes, R8/R9 routing
    for (int v = 0; v < NV; v++) begin
      logic [1:0] m; logic sw, slp; int ps, nt, to;
      {m, sw, slp} = VEC[v][16:13];
      ps = int'(VEC[v][12:8]);
      nt = int'(VEC[v][7:0]);
      to = exp_timeouts(m, sw, slp, ps, nt);
      en_mode = m; sw_en = sw;
      set_period(ps);
      pulse_clr();
      asleep = slp; cyc(2);
      zero_counts();
      ticks(nt);
      chk($sformatf("R2/R3/R11 vec%0d rst count", v), n_rst, slp ? 0 : to);
      chk($sformatf("R9 vec%0d wake count", v), n_wake, slp ? to : 0);
      asleep = 1'b0; cyc(2);
      pulse_clr();
    end

    // R1: long-held ticks count once each
    en_mode = 2'b11; sw_en = 1'b0; set_period(2); pulse_clr(); zero_counts();
    ticks(3, 10);
    chk("R1 three long ticks", n_rst, 0);
    ticks(1, 10);
    chk("R1 fourth long tick", n_rst, 1);
    // R8 flags after awake timeout
    chk("R10 to_n after awake timeout", to_n, 0);
    chk("R10 pd_n after awake timeout", pd_n, 1);
    pulse_clr();
    chk("R10 to_n after clear", to_n, 1);

    // R5: clear command discards progress
    zero_counts();
    ticks(3); pulse_clr(); ticks(3);
    chk("R5 clr_cmd restart", n_rst, 0);
    ticks(1);
    chk("R5 clr_cmd then full period", n_rst, 1);
    // R5: oscillator fail discards progress
    pulse_clr(); zero_counts();
    ticks(3); osc_fail = 1'b1; cyc(1); osc_fail = 1'b0; cyc(1); ticks(3);
    chk("R5 osc_fail restart", n_rst, 0);
    ticks(1);
    chk("R5 osc_fail then full period", n_rst, 1);

    // R7: disabling discards progress and ignores ticks
    en_mode = 2'b01; sw_en = 1'b1; pulse_clr(); zero_counts();
    ticks(3); sw_en = 1'b0; cyc(1); ticks(5); sw_en = 1'b1; cyc(1); ticks(3);
    chk("R7 disable restart", n_rst, 0);
    ticks(1);
    chk("R7 re-enabled full period", n_rst, 1);

    // R6: sleep entry clears and counting continues asleep; flags
    en_mode = 2'b11; pulse_clr(); zero_counts();
    ticks(3); asleep = 1'b1; cyc(2);
    chk("R10 pd_n after sleep entry", pd_n, 0);
    chk("R10 to_n after sleep entry", to_n, 1);
    ticks(3);
    chk("R6 entry restart", n_wake, 0);
    ticks(1);
    chk("R6 wake after full period asleep", n_wake, 1);
    chk("R9 no reset asleep", n_rst, 0);
    chk("R10 to_n after sleep timeout", to_n, 0);
    chk("R10 pd_n after sleep timeout", pd_n, 0);
    // R6: sleep exit clears
    zero_counts();
    ticks(3); asleep = 1'b0; cyc(2); ticks(3);
    chk("R6 exit restart", n_rst, 0);
    ticks(1);
    chk("R6 exit then full period", n_rst, 1);
    pulse_clr();
    chk("R10 pd_n after clear", pd_n, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule